// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the per-beat engine of a four-channel DMA controller. It keeps each channel's base and current address and word count, and each channel's mask and software request bits. It chooses one eligible channel by fixed or rotating priority and issues one bus transfer per beat. Each transfer carries a 16-bit address, a transfer type and a channel number. After each beat it steps the address and count. It finishes a transfer on count rollover or on an external end-of-process input. At completion it reloads the channel from its base registers or masks the channel, and it sends a one-cycle completion pulse to the status logic.

Software sets up a channel in three ways. A load strobe writes the base and current registers together. A packed per-channel mode field selects the behaviour. A whole-vector mask write enables channels. Peripherals request service on per-channel request lines. The bus side is a request/acknowledge handshake: a beat that moves data holds its request until it is acknowledged. A verify beat never raises the bus request and completes in one cycle.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, the bus request is low, the completion pulses are zero, and all four mask bits read 1.
- R2: A request line is honoured only while its mask bit is 0. While the disable input is high, no new channel is granted.
- R3: Each channel has a 6-bit mode field in mode_i. Bit 3 of the field set means the address steps down by one after each beat; clear means it steps up by one. bus_addr_o shows the granted channel's current address during every beat.
- R4: Mode field bits 1:0 give the transfer type on bus_type_o: 01 is memory write, 10 is memory read, 00 is verify. Write and read beats raise bus_req_o and hold address, channel and type until bus_ack_i. A verify beat never raises bus_req_o and takes one cycle.
- R5: A beat that completes while the current count is 0 ends the transfer, so a loaded count N gives N+1 beats. A beat that completes with eop_i high also ends it. The cycle after the ending beat, tc_o shows a one-cycle pulse on that channel's bit.
- R6: On completion with autoinitialize off (mode field bit 2 = 0), the channel's mask bit becomes 1.
- R7: On completion with autoinitialize on, the current address and count are reloaded from the base values and the mask bit is left unchanged.
- R8: Mode field bits 5:4 give the servicing style. 01 (single) drops the bus request for at least one cycle after each beat. 10 (block) runs to completion regardless of the request line. 00 (demand) keeps going while the channel stays eligible and pauses when it does not.
- R9: With rot_prio_i low, a lower channel number wins. With rot_prio_i high, the most recently granted channel has the lowest priority and the search starts at the next channel up.
- R10: A software request bit makes its channel eligible even when the channel is masked. The bit clears when that channel's transfer ends.
- R11: cfg_load_i writes cfg_addr_i and cfg_cnt_i into both the base and current registers of channel cfg_ch_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_load_i | input | 1 | Load base and current registers |
| cfg_ch_i | input | 2 | Channel to load |
| cfg_addr_i | input | 16 | Start address to load |
| cfg_cnt_i | input | 16 | Beat count minus one to load |
| mode_i | input | 24 | Four 6-bit mode fields, channel 0 in bits 5:0 |
| ctrl_dis_i | input | 1 | Block new grants |
| rot_prio_i | input | 1 | Rotating priority select |
| mask_wr_i | input | 1 | Write whole mask vector |
| mask_wdata_i | input | 4 | Mask value to write |
| sreq_wr_i | input | 1 | Write one software request bit |
| sreq_ch_i | input | 2 | Channel of software request write |
| sreq_val_i | input | 1 | Value of software request bit |
| dreq_i | input | 4 | Peripheral request lines |
| eop_i | input | 1 | External end of process |
| bus_req_o | output | 1 | Bus transfer request |
| bus_ack_i | input | 1 | Bus transfer acknowledge |
| bus_addr_o | output | 16 | Transfer address |
| bus_type_o | output | 2 | Transfer type |
| bus_ch_o | output | 2 | Granted channel |
| mask_o | output | 4 | Current mask bits |
| tc_o | output | 4 | Completion pulses |

## Verification
A corrupted current address shows on bus_addr_o at the very next beat of that channel. A wrong count shows later, at the end of the transfer, as a completion pulse that comes one or more beats early or late, together with a wrong mask bit. A wrong grant or priority pointer shows within one arbitration as a wrong bus_ch_o. A stuck software request or a continuation decision that ignores the servicing style shows as a bus request that rises when it should stay quiet, usually within two cycles.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {XT_VERIFY = 2'b00, XT_WRITE = 2'b01, XT_READ = 2'b10, XT_RSVD = 2'b11} xfer_type_e;
  typedef enum logic [1:0] {SV_DEMAND = 2'b00, SV_SINGLE = 2'b01, SV_BLOCK = 2'b10, SV_RSVD = 2'b11} svc_e;
  typedef struct packed {
    svc_e       svc;
    logic       dec;
    logic       auto_init;
    xfer_type_e typ;
  } ch_mode_t;
  typedef enum logic {ST_IDLE, ST_XFER} seq_state_e;
endpackage

// File: rtl/dma_ch_regs.sv
module dma_ch_regs #(
  parameter int AW    = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [AW-1:0]    load_addr_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             step_i,
  input  logic             dec_i,
  input  logic             reload_i,
  output logic [AW-1:0]    cur_addr_o,
  output logic [CNT_W-1:0] cur_cnt_o
);
  logic [AW-1:0]    base_addr_q;
  logic [CNT_W-1:0] base_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_o  <= '0;
      cur_cnt_o   <= '0;
    end else if (load_i) begin
      base_addr_q <= load_addr_i;
      base_cnt_q  <= load_cnt_i;
      cur_addr_o  <= load_addr_i;
      cur_cnt_o   <= load_cnt_i;
    end else if (step_i) begin
      if (reload_i) begin
        cur_addr_o <= base_addr_q;
        cur_cnt_o  <= base_cnt_q;
      end else begin
        cur_addr_o <= dec_i ? cur_addr_o - AW'(1) : cur_addr_o + AW'(1);
        cur_cnt_o  <= cur_cnt_o - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
  parameter int NUM_CH = 4,
  localparam int CHW = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] req_i,
  input  logic              rotate_i,
  input  logic [CHW-1:0]    last_i,
  output logic              valid_o,
  output logic [CHW-1:0]    gnt_o
);
  int base;

  always_comb begin
    base    = rotate_i ? int'(last_i) : NUM_CH - 1;
    valid_o = |req_i;
    gnt_o   = '0;
    // smallest offset past the base wins
    for (int k = NUM_CH; k >= 1; k--) begin
      if (req_i[(base + k) % NUM_CH]) gnt_o = CHW'((base + k) % NUM_CH);
    end
  end
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int CNT_W  = 16,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int MW    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_load_i,
  input  logic [CHW-1:0]       cfg_ch_i,
  input  logic [AW-1:0]        cfg_addr_i,
  input  logic [CNT_W-1:0]     cfg_cnt_i,
  input  logic [NUM_CH*MW-1:0] mode_i,
  input  logic                 ctrl_dis_i,
  input  logic                 rot_prio_i,
  input  logic                 mask_wr_i,
  input  logic [NUM_CH-1:0]    mask_wdata_i,
  input  logic                 sreq_wr_i,
  input  logic [CHW-1:0]       sreq_ch_i,
  input  logic                 sreq_val_i,
  input  logic [NUM_CH-1:0]    dreq_i,
  input  logic                 eop_i,
  output logic                 bus_req_o,
  input  logic                 bus_ack_i,
  output logic [AW-1:0]        bus_addr_o,
  output logic [1:0]           bus_type_o,
  output logic [CHW-1:0]       bus_ch_o,
  output logic [NUM_CH-1:0]    mask_o,
  output logic [NUM_CH-1:0]    tc_o
);
  ch_mode_t         mode [NUM_CH];
  logic [AW-1:0]    cur_addr [NUM_CH];
  logic [CNT_W-1:0] cur_cnt [NUM_CH];

  seq_state_e        state_q;
  logic [CHW-1:0]    act_q, last_q;
  logic [NUM_CH-1:0] mask_q, sreq_q, tc_q, elig;
  logic              arb_valid, strobe, beat_done, fin, keep_going;
  logic [CHW-1:0]    arb_gnt;
  ch_mode_t          act_mode;

  assign elig     = (dreq_i & ~mask_q) | sreq_q;
  assign act_mode = mode[act_q];
  assign strobe   = (state_q == ST_XFER) &&
                    (act_mode.typ == XT_WRITE || act_mode.typ == XT_READ);
  assign beat_done = (state_q == ST_XFER) && (strobe ? bus_ack_i : 1'b1);
  assign fin       = beat_done && ((cur_cnt[act_q] == '0) || eop_i);

  always_comb begin
    unique case (act_mode.svc)
      SV_BLOCK:  keep_going = 1'b1;
      SV_DEMAND: keep_going = elig[act_q];
      default:   keep_going = 1'b0;
    endcase
  end

  dma_prio_arb #(.NUM_CH(NUM_CH)) u_arb (
    .req_i   (elig),
    .rotate_i(rot_prio_i),
    .last_i  (last_q),
    .valid_o (arb_valid),
    .gnt_o   (arb_gnt)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign mode[g] = ch_mode_t'(mode_i[g*MW +: MW]);
    assign hit     = (act_q == CHW'(g));

    dma_ch_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (cfg_load_i && (cfg_ch_i == CHW'(g))),
      .load_addr_i(cfg_addr_i),
      .load_cnt_i (cfg_cnt_i),
      .step_i     (beat_done && hit),
      .dec_i      (mode[g].dec),
      .reload_i   (fin && mode[g].auto_init),
      .cur_addr_o (cur_addr[g]),
      .cur_cnt_o  (cur_cnt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
      last_q  <= '0;
      mask_q  <= '1;
      sreq_q  <= '0;
      tc_q    <= '0;
    end else begin
      tc_q <= '0;
      if (mask_wr_i) mask_q <= mask_wdata_i;
      if (sreq_wr_i) sreq_q[sreq_ch_i] <= sreq_val_i;
      unique case (state_q)
        ST_IDLE: begin
          if (arb_valid && !ctrl_dis_i) begin
            state_q <= ST_XFER;
            act_q   <= arb_gnt;
            last_q  <= arb_gnt;
          end
        end
        ST_XFER: begin
          // completion side effects win over same-cycle software writes
          if (fin) begin
            state_q        <= ST_IDLE;
            tc_q[act_q]    <= 1'b1;
            sreq_q[act_q]  <= 1'b0;
            if (!act_mode.auto_init) mask_q[act_q] <= 1'b1;
          end else if (beat_done && !keep_going) begin
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign bus_req_o  = strobe;
  assign bus_addr_o = cur_addr[act_q];
  assign bus_type_o = act_mode.typ;
  assign bus_ch_o   = act_q;
  assign mask_o     = mask_q;
  assign tc_o       = tc_q;
endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  localparam int CHW   = $clog2(NUM_CH),
  localparam int MW    = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CH*MW-1:0] mode_i,
  input logic                 ctrl_dis_i,
  input logic                 bus_req_o,
  input logic                 bus_ack_i,
  input logic [AW-1:0]        bus_addr_o,
  input logic [1:0]           bus_type_o,
  input logic [CHW-1:0]       bus_ch_o,
  input logic [NUM_CH-1:0]    mask_o,
  input logic [NUM_CH-1:0]    tc_o
);
  logic [MW-1:0]     cur_mode;
  logic [NUM_CH-1:0] auto_vec;

  assign cur_mode = mode_i[int'(bus_ch_o)*MW +: MW];
  for (genvar g = 0; g < NUM_CH; g++) begin : g_auto
    assign auto_vec[g] = mode_i[g*MW + 2];
  end

  assert_no_grant_disabled_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_req_o) |-> !$past(ctrl_dis_i));

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && $past(bus_req_o && bus_ack_i) && bus_ch_o == $past(bus_ch_o))
      |-> bus_addr_o == (cur_mode[3] ? $past(bus_addr_o) - AW'(1) : $past(bus_addr_o) + AW'(1)));

  assert_strobe_type_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_type_o == 2'b01 || bus_type_o == 2'b10));

  assert_hold_until_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_ch_o) && $stable(bus_type_o)));

  assert_tc_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tc_o));

  assert_tc_releases_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc_o) |-> !bus_req_o);

  assert_mask_on_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o & ~auto_vec & ~mask_o) == '0);

  assert_single_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_ack_i && cur_mode[5:4] == 2'b01) |=> !bus_req_o);
endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .ctrl_dis_i(ctrl_dis_i),
  .bus_req_o (bus_req_o),
  .bus_ack_i (bus_ack_i),
  .bus_addr_o(bus_addr_o),
  .bus_type_o(bus_type_o),
  .bus_ch_o  (bus_ch_o),
  .mask_o    (mask_o),
  .tc_o      (tc_o)
);

// File: tb/tb_dma_xfer_seq.sv
module tb_dma_xfer_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [15:0] cfg_addr = '0, cfg_cnt = '0;
  logic [5:0]  mode_b [4];
  logic [23:0] mode_w;
  logic        dis = 1'b0, rot = 1'b0;
  logic        mask_wr = 1'b0;
  logic [3:0]  mask_wdata = '0;
  logic        sreq_wr = 1'b0, sreq_val = 1'b0;
  logic [1:0]  sreq_ch = '0;
  logic [3:0]  dreq = '0;
  logic        eop = 1'b0;
  logic        ack = 1'b1;
  logic        bus_req_o;
  logic [15:0] bus_addr_o;
  logic [1:0]  bus_type_o, bus_ch_o;
  logic [3:0]  mask_o, tc_o;

  int errors = 0, checks = 0, cyc = 0;
  int beats [4];
  bit slow_ack = 1'b0;
  bit done_flag = 1'b0;

  assign mode_w = {mode_b[3], mode_b[2], mode_b[1], mode_b[0]};
  always #(CLK_PERIOD/2) clk = ~clk;

  dma_xfer_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_load_i(cfg_load), .cfg_ch_i(cfg_ch),
    .cfg_addr_i(cfg_addr), .cfg_cnt_i(cfg_cnt), .mode_i(mode_w),
    .ctrl_dis_i(dis), .rot_prio_i(rot), .mask_wr_i(mask_wr), .mask_wdata_i(mask_wdata),
    .sreq_wr_i(sreq_wr), .sreq_ch_i(sreq_ch), .sreq_val_i(sreq_val),
    .dreq_i(dreq), .eop_i(eop), .bus_req_o(bus_req_o), .bus_ack_i(ack),
    .bus_addr_o(bus_addr_o), .bus_type_o(bus_type_o), .bus_ch_o(bus_ch_o),
    .mask_o(mask_o), .tc_o(tc_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] mk(input int sv, input int dc, input int au, input int ty);
    return 6'((sv << 4) | (dc << 3) | (au << 2) | ty);
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_ba [4], m_bc [4], m_ca [4], m_cc [4];
  bit [3:0] m_mask, m_sreq, m_tc;
  bit m_busy;
  int m_ch, m_last;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; end
      m_mask = 4'hF; m_sreq = 0; m_tc = 0; m_busy = 0; m_ch = 0; m_last = 0;
    end else begin : upd
      bit [3:0] el;
      bit dn, fn;
      int t, sv, b;
      el = (dreq & ~m_mask) | m_sreq;
      dn = 0;
      if (m_busy) begin
        t  = int'(mode_b[m_ch][1:0]);
        dn = (t == 1 || t == 2) ? ack : 1'b1;
      end
      m_tc = 0;
      if (cfg_load) begin
        m_ba[cfg_ch] = cfg_addr; m_ca[cfg_ch] = cfg_addr;
        m_bc[cfg_ch] = cfg_cnt;  m_cc[cfg_ch] = cfg_cnt;
      end
      if (mask_wr) m_mask = mask_wdata;
      if (sreq_wr) m_sreq[sreq_ch] = sreq_val;
      if (dn) begin
        fn = (m_cc[m_ch] == 0) || eop;
        if (fn && mode_b[m_ch][2]) begin
          m_ca[m_ch] = m_ba[m_ch]; m_cc[m_ch] = m_bc[m_ch];
        end else begin
          m_ca[m_ch] = mode_b[m_ch][3] ? (m_ca[m_ch] - 1) & 'hFFFF : (m_ca[m_ch] + 1) & 'hFFFF;
          m_cc[m_ch] = (m_cc[m_ch] - 1) & 'hFFFF;
        end
        if (fn) begin
          if (!mode_b[m_ch][2]) m_mask[m_ch] = 1'b1;
          m_sreq[m_ch] = 1'b0;
          m_tc[m_ch] = 1'b1;
          m_busy = 0;
        end else begin
          sv = int'(mode_b[m_ch][5:4]);
          if (sv == 1 || sv == 3) m_busy = 0;
          else if (sv == 0 && !el[m_ch]) m_busy = 0;
        end
      end else if (!m_busy && !dis && el != 0) begin
        b = rot ? m_last : 3;
        for (int k = 4; k >= 1; k--) if (el[(b + k) % 4]) m_ch = (b + k) % 4;
        m_last = m_ch;
        m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin : cmp
      int t;
      bit er;
      t  = int'(mode_b[m_ch][1:0]);
      er = m_busy && (t == 1 || t == 2);
      chk(tc_o == m_tc, "R5 tc_o", int'(tc_o), int'(m_tc));
      chk(mask_o == m_mask, "R6 R7 mask_o", int'(mask_o), int'(m_mask));
      chk(bus_req_o == er, "R8 bus_req_o", int'(bus_req_o), int'(er));
      if (m_busy) begin
        chk(int'(bus_ch_o) == m_ch, "R9 bus_ch_o", int'(bus_ch_o), m_ch);
        chk(int'(bus_addr_o) == m_ca[m_ch], "R3 bus_addr_o", int'(bus_addr_o), m_ca[m_ch]);
        chk(int'(bus_type_o) == t, "R4 bus_type_o", int'(bus_type_o), t);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    if (bus_req_o && ack) beats[int'(bus_ch_o)]++;
    @(posedge clk); #1;
    cyc++;
    ack = slow_ack ? (cyc % 3 == 0) : 1'b1;
  endtask

  task automatic load(input int ch, input int a, input int c);
    cfg_load = 1'b1; cfg_ch = 2'(ch); cfg_addr = 16'(a); cfg_cnt = 16'(c);
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic set_mask(input logic [3:0] m);
    mask_wr = 1'b1; mask_wdata = m;
    tick();
    mask_wr = 1'b0;
  endtask

  task automatic wait_tc(input int ch, output bit seen);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      tick();
      if (tc_o[ch]) begin seen = 1; break; end
    end
  endtask

  task automatic next_grant(output int ch);
    bit prev;
    ch = -1;
    prev = bus_req_o;
    for (int i = 0; i < 60; i++) begin
      tick();
      if (bus_req_o && !prev) begin ch = int'(bus_ch_o); break; end
      prev = bus_req_o;
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin : main
    bit seen, rq;
    int g, b;
    for (int i = 0; i < 4; i++) begin mode_b[i] = '0; beats[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(bus_req_o == 1'b0, "R1 bus_req_o", int'(bus_req_o), 0);
    chk(mask_o == 4'hF, "R1 mask_o", int'(mask_o), 'hF);
    chk(tc_o == 4'h0, "R1 tc_o", int'(tc_o), 0);

    // single, increment, write, slow acknowledge
    slow_ack = 1'b1;
    mode_b[0] = mk(1, 0, 0, 1);
    load(0, 'h1000, 2);
    dreq = 4'b0001;
    repeat (5) tick();
    chk(bus_req_o == 1'b0, "R2 masked request", int'(bus_req_o), 0);
    set_mask(4'hE);
    next_grant(g);
    chk(g == 0, "R2 unmasked grant", g, 0);
    chk(bus_addr_o == 16'h1000, "R11 loaded address", int'(bus_addr_o), 'h1000);
    wait_tc(0, seen);
    chk(seen, "R5 tc ch0", int'(seen), 1);
    chk(beats[0] == 3, "R5 count plus one beats", beats[0], 3);
    chk(mask_o[0] == 1'b1, "R6 auto mask ch0", int'(mask_o[0]), 1);
    repeat (4) tick();
    chk(bus_req_o == 1'b0, "R2 remasked", int'(bus_req_o), 0);
    dreq = '0;

    // block, decrement, read
    mode_b[1] = mk(2, 1, 0, 2);
    load(1, 'h2000, 1);
    set_mask(4'hD);
    dreq = 4'b0010; tick(); dreq = '0;
    wait_tc(1, seen);
    chk(seen && beats[1] == 2, "R8 block runs without request", beats[1], 2);
    chk(mask_o[1] == 1'b1, "R6 auto mask ch1", int'(mask_o[1]), 1);

    // demand, autoinit, write, fast acknowledge
    slow_ack = 1'b0; tick();
    mode_b[2] = mk(0, 0, 1, 1);
    load(2, 'h3000, 3);
    set_mask(4'hB);
    dreq = 4'b0100;
    repeat (3) tick();
    dreq = '0;
    repeat (4) tick();
    chk(bus_req_o == 1'b0, "R8 demand pause", int'(bus_req_o), 0);
    chk(beats[2] == 3, "R8 demand beats before pause", beats[2], 3);
    dreq = 4'b0100;
    wait_tc(2, seen);
    chk(seen, "R5 tc ch2", int'(seen), 1);
    chk(mask_o[2] == 1'b0, "R7 mask kept", int'(mask_o[2]), 0);
    next_grant(g);
    chk(bus_addr_o == 16'h3000, "R7 reload address", int'(bus_addr_o), 'h3000);
    dreq = '0;
    set_mask(4'hF);
    repeat (4) tick();

    // priority
    mode_b[2] = mk(1, 0, 0, 1);
    mode_b[3] = mk(1, 0, 0, 1);
    load(2, 'h3100, 5);
    load(3, 'h3200, 5);
    set_mask(4'h3);
    dreq = 4'b1100;
    next_grant(g); chk(g == 2, "R9 fixed first", g, 2);
    next_grant(g); chk(g == 2, "R9 fixed again", g, 2);
    rot = 1'b1;
    next_grant(g); chk(g == 3, "R9 rotate to next", g, 3);
    next_grant(g); chk(g == 2, "R9 rotate back", g, 2);
    dreq = '0;
    set_mask(4'hF);
    repeat (4) tick();
    rot = 1'b0;

    // software request on a masked channel
    load(3, 'h4000, 0);
    b = beats[3];
    sreq_wr = 1'b1; sreq_ch = 2'd3; sreq_val = 1'b1;
    tick();
    sreq_wr = 1'b0;
    wait_tc(3, seen);
    chk(seen && beats[3] == b + 1, "R10 software request beat", beats[3] - b, 1);
    repeat (6) tick();
    chk(bus_req_o == 1'b0, "R10 request cleared", int'(bus_req_o), 0);

    // controller disable
    mode_b[0] = mk(1, 0, 0, 1);
    load(0, 'h6000, 0);
    dis = 1'b1;
    set_mask(4'hE);
    dreq = 4'b0001;
    repeat (6) tick();
    chk(bus_req_o == 1'b0, "R2 disabled", int'(bus_req_o), 0);
    dis = 1'b0;
    wait_tc(0, seen);
    chk(seen, "R2 enabled again", int'(seen), 1);
    dreq = '0;

    // external end of process in block mode
    mode_b[1] = mk(2, 0, 0, 1);
    load(1, 'h5000, 10);
    set_mask(4'hD);
    b = beats[1];
    dreq = 4'b0010; tick(); dreq = '0;
    for (int i = 0; i < 40 && beats[1] < b + 2; i++) tick();
    eop = 1'b1; tick(); eop = 1'b0;
    chk(tc_o[1] == 1'b1, "R5 eop ends transfer", int'(tc_o[1]), 1);
    chk(beats[1] - b == 3, "R5 eop beat count", beats[1] - b, 3);
    tick();
    chk(mask_o[1] == 1'b1, "R6 mask after eop", int'(mask_o[1]), 1);

    // verify transfers
    mode_b[0] = mk(1, 0, 0, 0);
    load(0, 'h7000, 2);
    set_mask(4'hE);
    dreq = 4'b0001;
    rq = 0; seen = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (bus_req_o) rq = 1;
      if (tc_o[0]) begin seen = 1; break; end
    end
    chk(!rq, "R4 verify no strobe", int'(rq), 0);
    chk(seen, "R4 verify completes", int'(seen), 1);
    dreq = '0;
    repeat (4) tick();

    summary();
    $finish;
  end
endmodule